// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the software-facing front end of an 8-line priority interrupt controller. It presents a byte-wide port with two addresses. Writes to it set up the controller through an ordered sequence of setup words and issue run-time commands: end-of-interrupt (EOI), priority rotation, read selection, special masking and poll arming. Reads return the request, in-service or mask vector, or a poll result that acknowledges the winning line.

The block holds the mask, the priority rotation offset, the vector base and the mode flags, and it drives them to a separate priority core. The core owns the request and in-service vectors and computes the winner. The core feeds back the current winning line and the highest-priority in-service line. This block turns commands into one-cycle pulses toward the core: a full clear, an in-service clear with a line number, and an acknowledge with a line number. A separate one-byte trigger-mode register is also held here. Each bit of it can only be set where a fixed per-instance mask allows.

Top module: `intc_cmd_port`

## Requirements
- R1: A write at address 0 with bit 4 set starts setup. It pulses `coreClear` and sets `singleMode` from bit 1. It clears the mask, offset, vector base, read select, special mask, auto-EOI, rotate-on-auto-EOI, nested mode and any armed poll.
- R2: The first address-1 write after setup start stores the data with its low three bits cleared as `vectorBase`. If bit 1 of the start word was 0, the cascade word comes next. If it was 1, the options word comes next only when bit 0 of the start word was 1; otherwise the block returns to normal operation.
- R3: The data of the cascade word has no effect. After it, the options word follows if bit 0 of the start word was set. In the options word, bit 4 sets `nestedMode` and bit 1 sets `autoEoi`, and the block then returns to normal operation.
- R4: In normal operation, a write at address 1 loads the mask.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll. Bit 1 set loads the read select from bit 0. Bit 6 set loads `specialMask` from bit 5. A cleared enable bit leaves its setting unchanged.
- R6: Other address-0 writes decode bits 7:5 as a command. Values 1 and 5 pulse `svcClrPulse` for `topSvcLine`, but only when `topSvcValid` is high. Value 5 also sets the offset to that line plus 1, modulo 8.
- R7: Command values 3 and 7 pulse an in-service clear of line data[2:0], and value 7 also sets the offset to that line plus 1. Value 6 sets the offset to data[2:0] plus 1, modulo 8. Values 0 and 4 set `rotateAutoEoi` from bit 7. Value 2 changes nothing.
- R8: When poll is armed, a read at either address returns 0x80 OR `winLine` and pulses `ackPulse` with `ackLine` if `winValid` is high, and returns 0 otherwise. Poll is then disarmed.
- R9: A read that is not a poll returns the in-service vector at address 0 when the read select is 1, and the request vector when it is 0. At address 1 it returns the mask.
- R10: A `trigWr` write stores `trigWrData` AND `TRIG_MASK` (default 0xDE). Reset clears the register.
- R11: An acknowledging poll read with both `autoEoi` and `rotateAutoEoi` set sets the offset to the acknowledged line plus 1.
- R12: All outputs change at the clock edge that samples the access. Every pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busAddr | input | 1 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| trigWr | input | 1 | Trigger-mode register write strobe |
| trigWrData | input | 8 | Trigger-mode write data |
| trigMode | output | 8 | Trigger-mode register |
| reqVec | input | 8 | Request vector from the core |
| svcVec | input | 8 | In-service vector from the core |
| winValid | input | 1 | Core has a line to deliver |
| winLine | input | 3 | Winning line number |
| topSvcValid | input | 1 | At least one in-service bit is set |
| topSvcLine | input | 3 | Highest-priority in-service line |
| coreClear | output | 1 | Pulse: clear core request and in-service state |
| svcClrPulse | output | 1 | Pulse: clear one in-service bit |
| svcClrLine | output | 3 | Line to clear |
| ackPulse | output | 1 | Pulse: acknowledge a line |
| ackLine | output | 3 | Line acknowledged |
| maskVec | output | 8 | Mask register |
| prioOffset | output | 3 | Priority rotation offset |
| vectorBase | output | 8 | Vector base, low bits zero |
| autoEoi | output | 1 | Automatic EOI enabled |
| rotateAutoEoi | output | 1 | Rotate on automatic EOI |
| nestedMode | output | 1 | Special fully nested mode |
| specialMask | output | 1 | Special mask mode |
| singleMode | output | 1 | Single-controller configuration |

## Verification
The assertions assume that `busWr` and `busRd` are never high in the same cycle. They also assume that the core inputs stay steady while an access is sampled. The bench keeps to both rules: each task drives one access at the falling edge and drops it one cycle later. The core vectors and winner lines are changed only between accesses. The pulse checks rely on this discipline, because a poll acknowledge or an EOI clear is tied to the single access that caused it.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
  // strobes from control to datapath, one per decoded action
  typedef struct packed {
    logic startInit;
    logic loadBase;
    logic loadOpts;
    logic loadMask;
    logic armPoll;
    logic loadReadSel;
    logic loadSpecMask;
    logic loadRotAeoi;
    logic clrHigh;
    logic clrHighRot;
    logic clrSpec;
    logic clrSpecRot;
    logic setOffset;
    logic pollRead;
    logic rdLow;
    logic rdHigh;
  } cmdStrb_t;

  // setup sequence position; IDLE means normal operation
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_OPTS = 2'd3
  } seqState_t;
endpackage

// File: rtl/intc_cmd_ctrl.sv
module intc_cmd_ctrl
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              pollArmed,
  output cmdStrb_t          strb,
  output logic              singleMode
);
  seqState_t seqState, seqNext;
  logic      needOpts;

  always_comb begin
    strb    = '0;
    seqNext = seqState;
    if (busWr && !busAddr) begin
      if (busWrData[4]) begin
        strb.startInit = 1'b1;
        seqNext        = SEQ_BASE;
      end else if (busWrData[3]) begin
        strb.armPoll      = busWrData[2];
        strb.loadReadSel  = busWrData[1];
        strb.loadSpecMask = busWrData[6];
      end else begin
        unique case (busWrData[7:5])
          3'd0, 3'd4: strb.loadRotAeoi = 1'b1;
          3'd1:       strb.clrHigh     = 1'b1;
          3'd5:       strb.clrHighRot  = 1'b1;
          3'd3:       strb.clrSpec     = 1'b1;
          3'd6:       strb.setOffset   = 1'b1;
          3'd7:       strb.clrSpecRot  = 1'b1;
          default:    ;
        endcase
      end
    end else if (busWr && busAddr) begin
      unique case (seqState)
        SEQ_IDLE: strb.loadMask = 1'b1;
        SEQ_BASE: begin
          strb.loadBase = 1'b1;
          if (!singleMode)   seqNext = SEQ_CASC;
          else if (needOpts) seqNext = SEQ_OPTS;
          else               seqNext = SEQ_IDLE;
        end
        SEQ_CASC: seqNext = needOpts ? SEQ_OPTS : SEQ_IDLE;
        SEQ_OPTS: begin
          strb.loadOpts = 1'b1;
          seqNext       = SEQ_IDLE;
        end
        default: seqNext = SEQ_IDLE;
      endcase
    end
    if (busRd) begin
      if (pollArmed)    strb.pollRead = 1'b1;
      else if (busAddr) strb.rdHigh   = 1'b1;
      else              strb.rdLow    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState   <= SEQ_IDLE;
      needOpts   <= 1'b0;
      singleMode <= 1'b0;
    end else begin
      seqState <= seqNext;
      if (strb.startInit) begin
        needOpts   <= busWrData[0];
        singleMode <= busWrData[1];
      end
    end
  end

  // R2: without single mode, the base word is always followed by the cascade word
  assert_base_to_casc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_BASE && busWr && busAddr && !singleMode) |=> seqState == SEQ_CASC);

  // R3: the options word always returns to normal operation
  assert_opts_to_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_OPTS && busWr && busAddr) |=> seqState == SEQ_IDLE);

  // R12: only one access per cycle is assumed from the bus
  assert_one_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));
endmodule

// File: rtl/intc_cmd_dp.sv
module intc_cmd_dp
  import intc_cmd_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              LINES     = 8,
  parameter logic [DATA_W-1:0] TRIG_MASK = 8'hDE
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cmdStrb_t                  strb,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  input  logic                      trigWr,
  input  logic [DATA_W-1:0]         trigWrData,
  output logic [DATA_W-1:0]         trigMode,
  input  logic [LINES-1:0]          reqVec,
  input  logic [LINES-1:0]          svcVec,
  input  logic                      winValid,
  input  logic [$clog2(LINES)-1:0]  winLine,
  input  logic                      topSvcValid,
  input  logic [$clog2(LINES)-1:0]  topSvcLine,
  output logic                      pollArmed,
  output logic                      coreClear,
  output logic                      svcClrPulse,
  output logic [$clog2(LINES)-1:0]  svcClrLine,
  output logic                      ackPulse,
  output logic [$clog2(LINES)-1:0]  ackLine,
  output logic [LINES-1:0]          maskVec,
  output logic [$clog2(LINES)-1:0]  prioOffset,
  output logic [DATA_W-1:0]         vectorBase,
  output logic                      autoEoi,
  output logic                      rotateAutoEoi,
  output logic                      nestedMode,
  output logic                      specialMask
);
  localparam int LINE_W = $clog2(LINES);
  localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'((1 << LINE_W) - 1);
  localparam int POLL_PAD = DATA_W - 1 - LINE_W;

  logic readSel;
  logic [LINE_W-1:0] dataLine;
  assign dataLine = busWrData[LINE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData     <= '0;
      pollArmed     <= 1'b0;
      coreClear     <= 1'b0;
      svcClrPulse   <= 1'b0;
      svcClrLine    <= '0;
      ackPulse      <= 1'b0;
      ackLine       <= '0;
      maskVec       <= '0;
      prioOffset    <= '0;
      vectorBase    <= '0;
      autoEoi       <= 1'b0;
      rotateAutoEoi <= 1'b0;
      nestedMode    <= 1'b0;
      specialMask   <= 1'b0;
      readSel       <= 1'b0;
    end else begin
      coreClear   <= 1'b0;
      svcClrPulse <= 1'b0;
      ackPulse    <= 1'b0;
      if (strb.startInit) begin
        coreClear     <= 1'b1;
        pollArmed     <= 1'b0;
        maskVec       <= '0;
        prioOffset    <= '0;
        vectorBase    <= '0;
        autoEoi       <= 1'b0;
        rotateAutoEoi <= 1'b0;
        nestedMode    <= 1'b0;
        specialMask   <= 1'b0;
        readSel       <= 1'b0;
      end
      if (strb.loadBase) vectorBase <= busWrData & BASE_KEEP;
      if (strb.loadOpts) begin
        nestedMode <= busWrData[4];
        autoEoi    <= busWrData[1];
      end
      if (strb.loadMask)     maskVec       <= busWrData[LINES-1:0];
      if (strb.armPoll)      pollArmed     <= 1'b1;
      if (strb.loadReadSel)  readSel       <= busWrData[0];
      if (strb.loadSpecMask) specialMask   <= busWrData[5];
      if (strb.loadRotAeoi)  rotateAutoEoi <= busWrData[7];
      if ((strb.clrHigh || strb.clrHighRot) && topSvcValid) begin
        svcClrPulse <= 1'b1;
        svcClrLine  <= topSvcLine;
        if (strb.clrHighRot) prioOffset <= topSvcLine + 1'b1;
      end
      if (strb.clrSpec || strb.clrSpecRot) begin
        svcClrPulse <= 1'b1;
        svcClrLine  <= dataLine;
        if (strb.clrSpecRot) prioOffset <= dataLine + 1'b1;
      end
      if (strb.setOffset) prioOffset <= dataLine + 1'b1;
      if (strb.pollRead) begin
        pollArmed <= 1'b0;
        if (winValid) begin
          busRdData <= {1'b1, {POLL_PAD{1'b0}}, winLine};
          ackPulse  <= 1'b1;
          ackLine   <= winLine;
          if (autoEoi && rotateAutoEoi) prioOffset <= winLine + 1'b1;
        end else begin
          busRdData <= '0;
        end
      end
      if (strb.rdLow)  busRdData <= DATA_W'(readSel ? svcVec : reqVec);
      if (strb.rdHigh) busRdData <= DATA_W'(maskVec);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       trigMode <= '0;
    else if (trigWr) trigMode <= trigWrData & TRIG_MASK;
  end

  // R1: a setup start leaves the held configuration cleared
  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.startInit |=> (maskVec == '0 && prioOffset == '0 && vectorBase == '0 &&
                        !autoEoi && !pollArmed && coreClear));

  // R6: a non-specific EOI with nothing in service produces no clear
  assert_eoi_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.clrHigh || strb.clrHighRot) && !topSvcValid) |=> !svcClrPulse);

  // R8: a poll read disarms poll
  assert_poll_disarm_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollRead |=> !pollArmed);

  // R8: an acknowledge comes with a poll word that names the same line
  assert_poll_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (busRdData[DATA_W-1] && busRdData[LINE_W-1:0] == ackLine));

  // R10: the trigger register takes only the permitted bits
  assert_trig_store_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigWr |=> trigMode == ($past(trigWrData) & TRIG_MASK));

  // R12: the pulses toward the core last one cycle for a single access
  assert_clear_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    (coreClear && !strb.startInit) |=> !coreClear);
endmodule

// File: rtl/intc_cmd_port.sv
module intc_cmd_port
  import intc_cmd_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                LINES     = 8,
  parameter logic [DATA_W-1:0] TRIG_MASK = 8'hDE
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWr,
  input  logic                      busRd,
  input  logic                      busAddr,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  input  logic                      trigWr,
  input  logic [DATA_W-1:0]         trigWrData,
  output logic [DATA_W-1:0]         trigMode,
  input  logic [LINES-1:0]          reqVec,
  input  logic [LINES-1:0]          svcVec,
  input  logic                      winValid,
  input  logic [$clog2(LINES)-1:0]  winLine,
  input  logic                      topSvcValid,
  input  logic [$clog2(LINES)-1:0]  topSvcLine,
  output logic                      coreClear,
  output logic                      svcClrPulse,
  output logic [$clog2(LINES)-1:0]  svcClrLine,
  output logic                      ackPulse,
  output logic [$clog2(LINES)-1:0]  ackLine,
  output logic [LINES-1:0]          maskVec,
  output logic [$clog2(LINES)-1:0]  prioOffset,
  output logic [DATA_W-1:0]         vectorBase,
  output logic                      autoEoi,
  output logic                      rotateAutoEoi,
  output logic                      nestedMode,
  output logic                      specialMask,
  output logic                      singleMode
);
  cmdStrb_t strb;
  logic     pollArmed;

  intc_cmd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .pollArmed (pollArmed),
    .strb      (strb),
    .singleMode(singleMode)
  );

  intc_cmd_dp #(.DATA_W(DATA_W), .LINES(LINES), .TRIG_MASK(TRIG_MASK)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .trigWr       (trigWr),
    .trigWrData   (trigWrData),
    .trigMode     (trigMode),
    .reqVec       (reqVec),
    .svcVec       (svcVec),
    .winValid     (winValid),
    .winLine      (winLine),
    .topSvcValid  (topSvcValid),
    .topSvcLine   (topSvcLine),
    .pollArmed    (pollArmed),
    .coreClear    (coreClear),
    .svcClrPulse  (svcClrPulse),
    .svcClrLine   (svcClrLine),
    .ackPulse     (ackPulse),
    .ackLine      (ackLine),
    .maskVec      (maskVec),
    .prioOffset   (prioOffset),
    .vectorBase   (vectorBase),
    .autoEoi      (autoEoi),
    .rotateAutoEoi(rotateAutoEoi),
    .nestedMode   (nestedMode),
    .specialMask  (specialMask)
  );
endmodule

// File: tb/intc_cmd_port_tb.sv
`timescale 1ns/1ps
module intc_cmd_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       trigWr = 1'b0;
  logic [7:0] trigWrData = '0;
  logic [7:0] trigMode;
  logic [7:0] reqVec = '0, svcVec = '0;
  logic       winValid = 1'b0, topSvcValid = 1'b0;
  logic [2:0] winLine = '0, topSvcLine = '0;
  logic       coreClear, svcClrPulse, ackPulse;
  logic [2:0] svcClrLine, ackLine, prioOffset;
  logic [7:0] maskVec, vectorBase;
  logic       autoEoi, rotateAutoEoi, nestedMode, specialMask, singleMode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  intc_cmd_port u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .trigWr(trigWr),
    .trigWrData(trigWrData), .trigMode(trigMode), .reqVec(reqVec), .svcVec(svcVec),
    .winValid(winValid), .winLine(winLine), .topSvcValid(topSvcValid),
    .topSvcLine(topSvcLine), .coreClear(coreClear), .svcClrPulse(svcClrPulse),
    .svcClrLine(svcClrLine), .ackPulse(ackPulse), .ackLine(ackLine),
    .maskVec(maskVec), .prioOffset(prioOffset), .vectorBase(vectorBase),
    .autoEoi(autoEoi), .rotateAutoEoi(rotateAutoEoi), .nestedMode(nestedMode),
    .specialMask(specialMask), .singleMode(singleMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 reset rd", busRdData, 8'h00);
    chk("R1 reset mask", maskVec, 8'h00);
    chk("R10 reset trig", trigMode, 8'h00);
    chk("R12 reset pulses", {coreClear, svcClrPulse, ackPulse}, 3'b000);
  endtask

  task automatic testSetupSingleOpts();
    wr(0, 8'h13);
    chk("R1 clear pulse", coreClear, 1'b1);
    chk("R1 single", singleMode, 1'b1);
    idle();
    chk("R12 clear one cycle", coreClear, 1'b0);
    wr(1, 8'h2F);
    chk("R2 base", vectorBase, 8'h28);
    wr(1, 8'h12);
    chk("R3 opts", {nestedMode, autoEoi}, 2'b11);
    wr(1, 8'h5A);
    chk("R4 mask", maskVec, 8'h5A);
  endtask

  task automatic testSetupCascade();
    wr(0, 8'h10);
    chk("R1 clears mask", maskVec, 8'h00);
    chk("R1 clears opts", {nestedMode, autoEoi}, 2'b00);
    chk("R1 single off", singleMode, 1'b0);
    wr(1, 8'h47);
    chk("R2 base cascade", vectorBase, 8'h40);
    wr(1, 8'hFF);
    chk("R3 cascade ignored", {maskVec, nestedMode, autoEoi}, 10'h0);
    wr(1, 8'h0F);
    chk("R4 mask after cascade", maskVec, 8'h0F);
  endtask

  task automatic testSetupCascadeOpts();
    wr(0, 8'h11);
    wr(1, 8'h08);
    wr(1, 8'hAA);
    chk("R3 cascade ignored 2", maskVec, 8'h00);
    wr(1, 8'h02);
    chk("R3 opts aeoi only", {nestedMode, autoEoi}, 2'b01);
    wr(1, 8'h33);
    chk("R4 mask after opts", maskVec, 8'h33);
  endtask

  task automatic testSetupSingleShort();
    wr(0, 8'h12);
    wr(1, 8'h60);
    chk("R2 base short", vectorBase, 8'h60);
    wr(1, 8'h81);
    chk("R2 short path to mask", maskVec, 8'h81);
    chk("R2 short path no opts", autoEoi, 1'b0);
  endtask

  task automatic testModeReads();
    reqVec = 8'h21; svcVec = 8'h84;
    rd(0);
    chk("R9 req read", busRdData, 8'h21);
    wr(0, 8'h0B);
    rd(0);
    chk("R5 R9 svc read", busRdData, 8'h84);
    wr(0, 8'h08);
    rd(0);
    chk("R5 readsel kept", busRdData, 8'h84);
    wr(0, 8'h0A);
    rd(0);
    chk("R5 readsel cleared", busRdData, 8'h21);
    rd(1);
    chk("R9 mask read", busRdData, 8'h81);
    wr(0, 8'h68);
    chk("R5 specmask on", specialMask, 1'b1);
    wr(0, 8'h28);
    chk("R5 specmask kept", specialMask, 1'b1);
    wr(0, 8'h48);
    chk("R5 specmask off", specialMask, 1'b0);
  endtask

  task automatic testEoi();
    topSvcValid = 1'b1; topSvcLine = 3'd5;
    wr(0, 8'h20);
    chk("R6 eoi pulse", {svcClrPulse, svcClrLine}, {1'b1, 3'd5});
    chk("R6 eoi no rotate", prioOffset, 3'd0);
    idle();
    chk("R12 eoi one cycle", svcClrPulse, 1'b0);
    topSvcLine = 3'd3;
    wr(0, 8'hA0);
    chk("R6 rot eoi pulse", {svcClrPulse, svcClrLine}, {1'b1, 3'd3});
    chk("R6 rot eoi offset", prioOffset, 3'd4);
    topSvcValid = 1'b0;
    wr(0, 8'h20);
    chk("R6 eoi none", svcClrPulse, 1'b0);
    wr(0, 8'hA0);
    chk("R6 rot eoi none", {svcClrPulse, prioOffset}, {1'b0, 3'd4});
    wr(0, 8'h66);
    chk("R7 specific eoi", {svcClrPulse, svcClrLine, prioOffset}, {1'b1, 3'd6, 3'd4});
    wr(0, 8'hE2);
    chk("R7 specific rot", {svcClrPulse, svcClrLine, prioOffset}, {1'b1, 3'd2, 3'd3});
    wr(0, 8'hC7);
    chk("R7 set offset wrap", {svcClrPulse, prioOffset}, {1'b0, 3'd0});
    wr(0, 8'h80);
    chk("R7 rot aeoi on", rotateAutoEoi, 1'b1);
    wr(0, 8'h40);
    chk("R7 cmd2 nothing", {svcClrPulse, rotateAutoEoi, prioOffset}, {1'b1 ^ 1'b1, 1'b1, 3'd0});
    wr(0, 8'h00);
    chk("R7 rot aeoi off", rotateAutoEoi, 1'b0);
  endtask

  task automatic testPoll();
    wr(0, 8'h0C);
    winValid = 1'b1; winLine = 3'd6;
    rd(1);
    chk("R8 poll word", busRdData, 8'h86);
    chk("R8 poll ack", {ackPulse, ackLine}, {1'b1, 3'd6});
    rd(1);
    chk("R8 poll disarmed", busRdData, 8'h81);
    chk("R12 ack one cycle", ackPulse, 1'b0);
    chk("R11 no rotate without aeoi", prioOffset, 3'd0);
    wr(0, 8'h0C);
    winValid = 1'b0;
    rd(0);
    chk("R8 poll empty", {busRdData, ackPulse}, 9'h0);
  endtask

  task automatic testAutoRotate();
    wr(0, 8'h13);
    wr(1, 8'h00);
    wr(1, 8'h02);
    wr(0, 8'h80);
    wr(0, 8'h0C);
    winValid = 1'b1; winLine = 3'd4;
    rd(0);
    chk("R11 poll word", busRdData, 8'h84);
    chk("R11 rotate offset", prioOffset, 3'd5);
    winValid = 1'b0;
  endtask

  task automatic testTrig();
    @(negedge clk);
    trigWr = 1'b1; trigWrData = 8'hFF;
    @(negedge clk);
    trigWr = 1'b0;
    chk("R10 trig masked all", trigMode, 8'hDE);
    @(negedge clk);
    trigWr = 1'b1; trigWrData = 8'h35;
    @(negedge clk);
    trigWr = 1'b0;
    chk("R10 trig masked", trigMode, 8'h14);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 trig reset", trigMode, 8'h00);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetupSingleOpts();
    testSetupCascade();
    testSetupCascadeOpts();
    testSetupSingleShort();
    testModeReads();
    testEoi();
    testPoll();
    testAutoRotate();
    testTrig();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule